// File: doc/BRIEF.md
# Serial Sync-Word Hunter

This block watches one serial data line and reports when a fixed 17-bit sync word has arrived on it. It divides the 100 MHz system clock down to a 0.5 µs bit strobe on its own, takes one sample of the line per strobe, and keeps a sliding window of the most recent samples. When the window equals the sync word, it raises a single-cycle `found` pulse.

A controlling state machine arms the search by holding `arm` high. While `arm` is low, the line is ignored and all search state is wiped. Each time `arm` rises, the bit divider starts again from zero, so the first sample is taken one full bit period after arming. Recovering the sender's clock, aligning to its bit edges, and acting on the pulse are the job of the surrounding logic.

Top module: `sync_word_hunter`

## Requirements
- R1: After the synchronous reset `rst` is released with `arm` low, `found` reads 0.
- R2: While `arm` is held high, the line is sampled once every `CLK_PER_BIT` clocks (50 by default, giving 0.5 µs at 100 MHz). The first sample is taken on the `CLK_PER_BIT`-th rising edge at which `arm` is seen high.
- R3: Each sample enters the window at bit 0, and the older samples move one place toward bit 16. A match means the first-sent bit sits at bit 16. The sync word, in sending order, is 1,0,1,0,0,0,0,1,0,1,0,0,0,0,0,0,1, which is the window value 17'h14281.
- R4: `found` is high for exactly one clock. That clock is the one right after the sampling edge that completed the match.
- R5: No match is declared until 17 samples have been taken since the search was last armed, so 16 trailing bits of the word are not enough.
- R6: While `arm` is low, `found` stays 0 and the line has no effect. Dropping `arm` clears the window and the sample count, so a word split across a disarm is not detected.
- R7: A match is found at any bit alignment, including after any number of unrelated leading bits.
- R8: A rise of `arm` restarts the bit divider, so sampling lines up with the new arming and not with any earlier count.
- R9: A 17-bit sequence that differs from the sync word in any single bit produces no pulse.
- R10: The word sent twice back to back gives two pulses, one at the end of each copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| arm | input | 1 | Search enable; the search state clears while it is low |
| line_in | input | 1 | Serial data line |
| found | output | 1 | One-cycle pulse when the sync word is detected |

## Verification
The assertions assume that `line_in` is already synchronous to `clk` and holds its level across each sampling edge. They also assume `CLK_PER_BIT` is at least 2, so a rise of `arm` can never coincide with a strobe. The stimulus changes `line_in` and `arm` only on falling clock edges. It holds each bit for exactly `CLK_PER_BIT` clocks, counted from the falling edge at which `arm` was raised, so every sampling edge sees a stable bit.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;

    // 100 MHz system clock, 0.5 us bit period
    localparam int unsigned SYS_CLK_MHZ     = 100;
    localparam int unsigned BIT_TIME_NS     = 500;
    localparam int unsigned DEF_CLK_PER_BIT = (SYS_CLK_MHZ * BIT_TIME_NS) / 1000;

    // Sync word, first-sent bit at the MSB
    localparam int unsigned DEF_WORD_LEN = 17;
    localparam logic [DEF_WORD_LEN-1:0] DEF_WORD = 17'b1_0100_0010_1000_0001;

    // Width that holds values 0..n
    function automatic int unsigned count_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sync_hunt_strobe.sv
module sync_hunt_strobe #(
    parameter int unsigned DIV = sync_hunt_pkg::DEF_CLK_PER_BIT
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic strobe
);
    localparam int unsigned CW = sync_hunt_pkg::count_width(DIV - 1);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_q;

    // Counter is held at zero while disarmed, so each arming starts a fresh period
    always_ff @(posedge clk) begin
        if (rst || !arm) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign strobe = !rst && arm && (div_q == LAST);

endmodule

// File: rtl/sync_hunt_window.sv
module sync_hunt_window #(
    parameter int unsigned LEN = sync_hunt_pkg::DEF_WORD_LEN
) (
    input  logic                                          clk,
    input  logic                                          rst,
    input  logic                                          arm,
    input  logic                                          strobe,
    input  logic                                          line_in,
    output logic [LEN-1:0]                                win_q,
    output logic [sync_hunt_pkg::count_width(LEN)-1:0]    fill_q,
    output logic [LEN-1:0]                                win_nxt,
    output logic                                          full_nxt
);
    localparam int unsigned FW = sync_hunt_pkg::count_width(LEN);
    localparam logic [FW-1:0] FULL = FW'(LEN);

    typedef struct packed {
        logic [LEN-1:0] bits;
        logic [FW-1:0]  fill;
    } win_state_t;

    win_state_t st_q, st_d;

    // Newest sample at bit 0, oldest toward the MSB
    assign win_nxt  = {st_q.bits[LEN-2:0], line_in};
    assign full_nxt = (st_q.fill >= FW'(LEN - 1));

    always_comb begin
        st_d = st_q;
        if (strobe) begin
            st_d.bits = win_nxt;
            if (st_q.fill != FULL) begin
                st_d.fill = st_q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !arm) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_q  = st_q.bits;
    assign fill_q = st_q.fill;

endmodule

// File: rtl/sync_hunt_match.sv
module sync_hunt_match #(
    parameter int unsigned        LEN  = sync_hunt_pkg::DEF_WORD_LEN,
    parameter logic [LEN-1:0]     WORD = sync_hunt_pkg::DEF_WORD
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           arm,
    input  logic           strobe,
    input  logic           full_nxt,
    input  logic [LEN-1:0] win_nxt,
    output logic           found_q
);
    logic [LEN-1:0] bit_eq;

    for (genvar i = 0; i < LEN; i++) begin : g_cmp
        assign bit_eq[i] = (win_nxt[i] == WORD[i]);
    end

    logic hit;
    assign hit = arm && strobe && full_nxt && (&bit_eq);

    always_ff @(posedge clk) begin
        if (rst) begin
            found_q <= 1'b0;
        end else begin
            found_q <= hit;
        end
    end

endmodule

// File: rtl/sync_word_hunter.sv
module sync_word_hunter #(
    parameter int unsigned             CLK_PER_BIT = sync_hunt_pkg::DEF_CLK_PER_BIT,
    parameter int unsigned             WORD_LEN    = sync_hunt_pkg::DEF_WORD_LEN,
    parameter logic [WORD_LEN-1:0]     WORD        = sync_hunt_pkg::DEF_WORD
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic line_in,
    output logic found
);
    localparam int unsigned FW = sync_hunt_pkg::count_width(WORD_LEN);

    logic                bit_stb;
    logic [WORD_LEN-1:0] win_q;
    logic [WORD_LEN-1:0] win_nxt;
    logic [FW-1:0]       fill_q;
    logic                full_nxt;

    sync_hunt_strobe #(.DIV(CLK_PER_BIT)) strobe_i (
        .clk    (clk),
        .rst    (rst),
        .arm    (arm),
        .strobe (bit_stb)
    );

    sync_hunt_window #(.LEN(WORD_LEN)) window_i (
        .clk      (clk),
        .rst      (rst),
        .arm      (arm),
        .strobe   (bit_stb),
        .line_in  (line_in),
        .win_q    (win_q),
        .fill_q   (fill_q),
        .win_nxt  (win_nxt),
        .full_nxt (full_nxt)
    );

    sync_hunt_match #(.LEN(WORD_LEN), .WORD(WORD)) match_i (
        .clk      (clk),
        .rst      (rst),
        .arm      (arm),
        .strobe   (bit_stb),
        .full_nxt (full_nxt),
        .win_nxt  (win_nxt),
        .found_q  (found)
    );

endmodule

// File: rtl/sync_word_hunter_chk.sv
module sync_word_hunter_chk #(
    parameter int unsigned         DIV  = 50,
    parameter int unsigned         LEN  = 17,
    parameter logic [LEN-1:0]      WORD = '0
) (
    input logic                                       clk,
    input logic                                       rst,
    input logic                                       arm,
    input logic                                       line_in,
    input logic                                       found,
    input logic                                       strobe,
    input logic [LEN-1:0]                             win,
    input logic [sync_hunt_pkg::count_width(LEN)-1:0] fill
);
    localparam int unsigned FW = sync_hunt_pkg::count_width(LEN);

    // Clocks since arming or since the last strobe
    int unsigned gap;
    always_ff @(posedge clk) begin
        if (rst || !arm || strobe) begin
            gap <= 0;
        end else begin
            gap <= gap + 1;
        end
    end

    AST_STROBE_PERIOD:  assert property (@(posedge clk) disable iff (rst) strobe |-> (gap == DIV - 1)); // R2
    AST_STROBE_ARMED:   assert property (@(posedge clk) disable iff (rst) strobe |-> arm); // R6
    AST_RESTART_ON_ARM: assert property (@(posedge clk) disable iff (rst) $rose(arm) |-> !strobe); // R8
    AST_SHIFT_IN:       assert property (@(posedge clk) disable iff (rst) strobe |=> (win[0] == $past(line_in))); // R3
    AST_SHIFT_UP:       assert property (@(posedge clk) disable iff (rst) strobe |=> (win[LEN-1:1] == $past(win[LEN-2:0]))); // R3
    AST_PULSE_SINGLE:   assert property (@(posedge clk) disable iff (rst) found |=> !found); // R4
    AST_PULSE_AFTER:    assert property (@(posedge clk) disable iff (rst) found |-> $past(strobe)); // R4
    AST_FULL_BEFORE:    assert property (@(posedge clk) disable iff (rst) found |-> (fill == FW'(LEN))); // R5
    AST_MATCH_WORD:     assert property (@(posedge clk) disable iff (rst) found |-> (win == WORD)); // R3
    AST_IDLE_CLEARS:    assert property (@(posedge clk) disable iff (rst) !arm |=> (fill == '0 && win == '0 && !found)); // R6

endmodule

bind sync_word_hunter sync_word_hunter_chk #(
    .DIV  (CLK_PER_BIT),
    .LEN  (WORD_LEN),
    .WORD (WORD)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .arm     (arm),
    .line_in (line_in),
    .found   (found),
    .strobe  (bit_stb),
    .win     (win_q),
    .fill    (fill_q)
);

// File: tb/sync_word_hunter_tb_top.sv
module sync_word_hunter_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned DIV = 50;
    localparam int unsigned LEN = 17;
    localparam logic [LEN-1:0] SYNC = 17'h14281;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arm = 1'b0;
    logic line_in = 1'b0;
    logic found;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sync_word_hunter dut_i (
        .clk     (clk),
        .rst     (rst),
        .arm     (arm),
        .line_in (line_in),
        .found   (found)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Sends bits[n-1] first; counts pulses at the sampling point and elsewhere
    task automatic send_seq(input logic [63:0] bits, input int n,
                            output int on_time, output int early, output int last_idx);
        on_time = 0; early = 0; last_idx = -1;
        for (int k = n - 1; k >= 0; k--) begin
            line_in = bits[k];
            for (int c = 0; c < int'(DIV); c++) begin
                @(posedge clk);
                @(negedge clk);
                if (found) begin
                    if (c == int'(DIV) - 1) begin
                        on_time++;
                        last_idx = n - 1 - k;
                    end else begin
                        early++;
                    end
                end
            end
        end
    endtask

    task automatic rearm();
        arm = 1'b0;
        @(posedge clk);
        @(negedge clk);
        arm = 1'b1;
    endtask

    task automatic t_reset();
        int seen = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            seen += int'(found);
        end
        check(seen == 0, "R1 found after reset", seen, 0);
    endtask

    task automatic t_exact();
        int ot, ea, li;
        rearm();
        send_seq(64'(SYNC), LEN, ot, ea, li);
        check(ot == 1, "R3 exact word pulse count", ot, 1);
        check(li == 16, "R2 pulse after 17th sample", li, 16);
        check(ea == 0, "R4 no off-timing pulse", ea, 0);
    endtask

    task automatic t_junk();
        int ot, ea, li;
        rearm();
        send_seq({5'b11011, SYNC}, LEN + 5, ot, ea, li);
        check(ot == 1 && ea == 0, "R7 match after leading bits", ot + ea, 1);
        check(li == 21, "R7 pulse position", li, 21);
    endtask

    task automatic t_repeat();
        int ot, ea, li;
        rearm();
        send_seq({SYNC, SYNC}, 2 * LEN, ot, ea, li);
        check(ot == 2 && ea == 0, "R10 two pulses for two copies", ot + ea, 2);
        check(li == 33, "R10 second pulse position", li, 33);
    endtask

    task automatic t_near();
        int ot, ea, li;
        rearm();
        send_seq(64'(SYNC ^ 17'h00001), LEN, ot, ea, li);
        check(ot + ea == 0, "R9 last bit flipped", ot + ea, 0);
        rearm();
        send_seq(64'(SYNC ^ 17'h10000), LEN, ot, ea, li);
        check(ot + ea == 0, "R9 first bit flipped", ot + ea, 0);
        rearm();
        send_seq(64'(SYNC ^ 17'h00400), LEN, ot, ea, li);
        check(ot + ea == 0, "R9 middle bit flipped", ot + ea, 0);
    endtask

    task automatic t_short();
        int ot, ea, li;
        rearm();
        send_seq(64'(SYNC[LEN-2:0]), LEN - 1, ot, ea, li);
        check(ot + ea == 0, "R5 sixteen bits give no pulse", ot + ea, 0);
    endtask

    task automatic t_disarmed();
        int ot, ea, li;
        arm = 1'b0;
        @(posedge clk);
        @(negedge clk);
        send_seq(64'(SYNC), LEN, ot, ea, li);
        check(ot + ea == 0, "R6 line ignored while disarmed", ot + ea, 0);
    endtask

    task automatic t_split();
        int ot, ea, li;
        rearm();
        send_seq(64'(SYNC[LEN-1:7]), 10, ot, ea, li);
        check(ot + ea == 0, "R6 first part no pulse", ot + ea, 0);
        rearm();
        send_seq(64'(SYNC[6:0]), 7, ot, ea, li);
        check(ot + ea == 0, "R6 split word not detected", ot + ea, 0);
        send_seq(64'(SYNC), LEN, ot, ea, li);
        check(ot == 1 && ea == 0 && li == 16, "R6 full word after split", li, 16);
    endtask

    task automatic t_restart();
        int ot, ea, li;
        rearm();
        repeat (23) @(negedge clk);
        rearm();
        send_seq(64'(SYNC), LEN, ot, ea, li);
        check(ot == 1 && ea == 0, "R8 sampling realigned to new arm", ot + ea, 1);
        check(li == 16, "R8 pulse position", li, 16);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(5ns * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        t_reset();
        t_exact();
        t_junk();
        t_repeat();
        t_near();
        t_short();
        t_disarmed();
        t_split();
        t_restart();
        finish_run();
    end

endmodule